// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block gathers 32 level-sensitive interrupt lines from peripherals and presents them to a processor core. Line 0 is not connected. Lines 1 to 29 are ordinary sources, and each one is captured into a raw pending word. Software writes a mask word, and the controller forms a masked pending word from it. From the masked word it produces one vector code for the core, together with a request line.

The controller does not arbitrate between sources. If exactly one masked source is active, the vector names that source. If several are active, the vector carries one shared "multiple" code, and the handler software reads the masked pending word to decide the order.

The two top lines, 30 and 31, bypass masking and vectoring. They set bits in a separate non-maskable pending word, and that word drives its own request line.

The register port is word-addressed and always a full 32 bits wide. Reads are combinational on the address. Writes take effect at the clock edge.

Top module: `vlic_top`

## Requirements
- R1: After reset the mask, raw pending, masked pending and non-maskable pending words all read as zero, and `core_vec`, `core_irq` and `core_nmi` are all 0.
- R2: A write to word 0 loads the full 32-bit mask at the clock edge, and the mask reads back unchanged. Writes to words 1 to 7 change no register and no output.
- R3: Raw pending bit n-1 (word 1) holds the level that line n had at the previous clock edge, for n from 1 to 29. Line 0 has no effect, and raw bits 29 to 31 read as zero.
- R4: The masked pending word (word 2) always equals raw pending AND mask.
- R5: When exactly one masked pending bit is set, at position i, `core_vec` equals 0x31 + i.
- R6: When two or more masked pending bits are set, `core_vec` equals 0x30.
- R7: When no masked pending bit is set, `core_vec` is 0. `core_irq` is 1 exactly when `core_vec` is nonzero.
- R8: Lines 30 and 31 never touch raw pending or the vector. Each one follows its level into bit 30 or bit 31 of the non-maskable pending word (word 3), one clock later. `core_nmi` is the OR of that word.
- R9: Word 4 always reads zero, and so do word addresses 5 to 7.
- R10: The vector and both request outputs follow the registers combinationally, so they change in the same cycle as the mask write or line capture that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 32 | Level interrupt lines from the sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address of the register port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational on `addr` |
| core_irq | output | 1 | Maskable interrupt request to the core |
| core_vec | output | 8 | Vector code to the core |
| core_nmi | output | 1 | Non-maskable request to the core |

## Verification
The bench builds the block with its default values: 32 lines, the non-maskable group starting at line 30, and a 3-bit word address. This configuration covers the highest ordinary source (vector 0x4D). It also covers both non-maskable lines and all three unmapped addresses above the status word. With these values, every edge case in the register map and in the vector encoding can be reached through the port.

// File: rtl/vlic_pkg.sv
package vlic_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned VEC_W  = 8;
  localparam logic [VEC_W-1:0] VEC_NONE  = 8'h00;
  localparam logic [VEC_W-1:0] VEC_MULTI = 8'h30;
  localparam logic [VEC_W-1:0] VEC_BASE  = 8'h31;

  typedef enum logic [2:0] {
    OFS_MASK   = 3'd0,
    OFS_RAW    = 3'd1,
    OFS_MASKED = 3'd2,
    OFS_NMI    = 3'd3,
    OFS_STATUS = 3'd4
  } vlic_ofs_e;

  // Scan bits 0..WORD_W-2; one hit -> base+position, several -> shared code
  function automatic logic [VEC_W-1:0] vlic_encode_f(input logic [WORD_W-1:0] pend);
    int unsigned cnt;
    int unsigned first;
    cnt = 0;
    first = 0;
    for (int unsigned i = 0; i < WORD_W - 1; i++) begin
      if (pend[i]) begin
        if (cnt == 0) first = i;
        cnt++;
      end
    end
    if (cnt == 0)      return VEC_NONE;
    else if (cnt > 1)  return VEC_MULTI;
    else               return VEC_BASE + VEC_W'(first);
  endfunction
endpackage

// File: rtl/vlic_capture.sv
module vlic_capture
  import vlic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned NMI_FIRST = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  output logic [WORD_W-1:0]    raw_pend,
  output logic [WORD_W-1:0]    nmi_pend
);
  localparam int unsigned RAW_W = NMI_FIRST - 1;

  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    if (g < RAW_W) begin : g_raw
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= lines[g+1];
      end
      assign raw_pend[g] = q;
    end else begin : g_raw_zero
      assign raw_pend[g] = 1'b0;
    end

    if (g >= NMI_FIRST && g < NUM_LINES) begin : g_nmi
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= lines[g];
      end
      assign nmi_pend[g] = q;
    end else begin : g_nmi_zero
      assign nmi_pend[g] = 1'b0;
    end
  end
endmodule

// File: rtl/vlic_regs.sv
module vlic_regs
  import vlic_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] raw_pend,
  input  logic [WORD_W-1:0] nmi_pend,
  output logic [WORD_W-1:0] mask_q,
  output logic [WORD_W-1:0] masked_pend,
  output logic [WORD_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wdata;
  end

  assign masked_pend = raw_pend & mask_q;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFS_MASK):   rdata = mask_q;
      ADDR_W'(OFS_RAW):    rdata = raw_pend;
      ADDR_W'(OFS_MASKED): rdata = masked_pend;
      ADDR_W'(OFS_NMI):    rdata = nmi_pend;
      default:             rdata = '0;
    endcase
  end
endmodule

// File: rtl/vlic_vector.sv
module vlic_vector
  import vlic_pkg::*;
(
  input  logic [WORD_W-1:0] masked_pend,
  output logic [VEC_W-1:0]  vec,
  output logic              irq
);
  assign vec = vlic_encode_f(masked_pend);
  assign irq = |masked_pend;
endmodule

// File: rtl/vlic_top.sv
module vlic_top
  import vlic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned NMI_FIRST = 30,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic                 core_irq,
  output logic [VEC_W-1:0]     core_vec,
  output logic                 core_nmi
);
  logic              mask_wr;
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] raw_pend;
  logic [WORD_W-1:0] masked_pend;
  logic [WORD_W-1:0] nmi_pend;

  assign mask_wr = wr_en && (addr == ADDR_W'(OFS_MASK));

  vlic_capture #(.NUM_LINES(NUM_LINES), .NMI_FIRST(NMI_FIRST)) u_capture (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines),
    .raw_pend(raw_pend), .nmi_pend(nmi_pend)
  );

  vlic_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .addr(addr), .wdata(wdata),
    .raw_pend(raw_pend), .nmi_pend(nmi_pend),
    .mask_q(mask_q), .masked_pend(masked_pend), .rdata(rdata)
  );

  vlic_vector u_vector (
    .masked_pend(masked_pend), .vec(core_vec), .irq(core_irq)
  );

  assign core_nmi = |nmi_pend;
endmodule

// File: rtl/vlic_checker.sv
module vlic_checker
  import vlic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned NMI_FIRST = 30
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 mask_wr,
  input logic [WORD_W-1:0]    wdata,
  input logic [WORD_W-1:0]    mask_q,
  input logic [WORD_W-1:0]    raw_pend,
  input logic [WORD_W-1:0]    masked_pend,
  input logic [VEC_W-1:0]     core_vec,
  input logic                 core_irq,
  input logic                 core_nmi
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_q == $past(wdata)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q)); // R2
  AST_RAW_TRACK: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    raw_pend[NMI_FIRST-2:0] == $past(irq_lines[NMI_FIRST-1:1])); // R3
  AST_SINGLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(masked_pend) == 1) |-> (core_vec >= VEC_BASE && core_vec < VEC_BASE + 8'(NMI_FIRST-1))); // R5
  AST_MULTI_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(masked_pend) > 1) |-> core_vec == VEC_MULTI); // R6
  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq == (core_vec != VEC_NONE)); // R7
  AST_NMI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lines[NUM_LINES-1] |=> core_nmi); // R8
endmodule

bind vlic_top vlic_checker #(.NUM_LINES(NUM_LINES), .NMI_FIRST(NMI_FIRST)) i_chk (.*);

// File: tb/test_vlic_top.sv
module test_vlic_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        core_irq;
  logic [7:0]  core_vec;
  logic        core_nmi;

  int total = 0;
  int bad = 0;
  logic [31:0] rd;

  // stimulus table: mask, lines, expected vector
  localparam logic [31:0] T_MASK [N] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0010, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] T_LINE [N] = '{32'h0000_0000, 32'h0000_0002, 32'h2000_0000,
    32'h0000_0022, 32'h0000_0022, 32'h0000_0022, 32'h3FFF_FFFE, 32'h0000_0001, 32'h4000_0000};
  localparam logic [7:0]  T_VEC  [N] = '{8'h00, 8'h31, 8'h4D, 8'h30, 8'h31, 8'h35, 8'h00, 8'h00, 8'h00};

  vlic_top i_vlic_top (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .core_irq(core_irq), .core_vec(core_vec), .core_nmi(core_nmi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive_lines(input logic [31:0] v);
    @(negedge clk);
    irq_lines = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, checked while reset is held and after release
    check("R1 vec in reset", {24'h0, core_vec}, 32'h0);
    check("R1 irq/nmi in reset", {30'h0, core_irq, core_nmi}, 32'h0);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      read_reg(3'(a), rd);
      check("R1 register zero after reset", rd, 32'h0);
    end

    // Table walk: R4 R5 R6 R7 R10
    for (int k = 0; k < N; k++) begin
      write_reg(3'd0, T_MASK[k]);
      drive_lines(T_LINE[k]);
      #1;
      check("R5/R6/R7 vector", {24'h0, core_vec}, {24'h0, T_VEC[k]});
      check("R7 irq vs vector", {31'h0, core_irq}, {31'h0, T_VEC[k] != 8'h00});
      read_reg(3'd2, rd);
      check("R4 masked word", rd, {3'b000, T_LINE[k][29:1]} & T_MASK[k]);
      read_reg(3'd1, rd);
      check("R3 raw word", rd, {3'b000, T_LINE[k][29:1]});
    end

    // R10: mask write acts in the cycle it lands
    drive_lines(32'h0000_0008);          // raw bit 2
    @(negedge clk); wr_en = 1'b1; addr = 3'd0; wdata = 32'h0;
    @(negedge clk); wr_en = 1'b0;
    #1 check("R10 vector clears with mask write", {24'h0, core_vec}, 32'h0);
    @(negedge clk); wr_en = 1'b1; addr = 3'd0; wdata = 32'h0000_0004;
    @(posedge clk); #1;
    check("R10 vector after mask edge", {24'h0, core_vec}, 32'h33);
    @(negedge clk); wr_en = 1'b0;

    // R2: writes to other words ignored
    write_reg(3'd0, 32'hA5A5_0004);
    for (int a = 1; a < 8; a++) write_reg(3'(a), 32'hFFFF_FFFF);
    read_reg(3'd0, rd);
    check("R2 mask readback after stray writes", rd, 32'hA5A5_0004);
    read_reg(3'd1, rd);
    check("R2 raw unchanged by write", rd, 32'h0000_0004);
    read_reg(3'd3, rd);
    check("R2 nmi word unchanged by write", rd, 32'h0);
    check("R2 vector unchanged", {24'h0, core_vec}, 32'h33);

    // R9 status and unmapped words
    for (int a = 4; a < 8; a++) begin
      read_reg(3'(a), rd);
      check("R9 zero word", rd, 32'h0);
    end

    // R8 non-maskable path
    write_reg(3'd0, 32'hFFFF_FFFF);
    drive_lines(32'h8000_0000);
    #1 check("R8 nmi from line 31", {31'h0, core_nmi}, 32'h1);
    check("R8 no maskable irq", {31'h0, core_irq}, 32'h0);
    read_reg(3'd3, rd);
    check("R8 nmi word bit31", rd, 32'h8000_0000);
    drive_lines(32'h4000_0000);
    read_reg(3'd3, rd);
    check("R8 nmi word bit30", rd, 32'h4000_0000);
    read_reg(3'd1, rd);
    check("R8 raw untouched", rd, 32'h0);
    drive_lines(32'h0);
    #1 check("R8 nmi released", {31'h0, core_nmi}, 32'h0);

    // R3 line 0 alone
    drive_lines(32'h0000_0001);
    read_reg(3'd1, rd);
    check("R3 line 0 ignored", rd, 32'h0);

    // R1 reset mid-run
    drive_lines(32'hC000_0006);
    @(negedge clk); rst_n = 1'b0; irq_lines = '0;
    #1 check("R1 outputs after reset", {22'h0, core_vec, core_irq, core_nmi}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    read_reg(3'd0, rd);
    check("R1 mask cleared", rd, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule